// File: doc/BRIEF.md
# PLL Setting Search Engine

This block finds the multiplier and divider settings of a programmable PLL for a requested output rate. A start pulse samples two unsigned integers, the reference (parent) rate and the target rate. The engine then walks the setting space in a fixed order. Each candidate rate is parent × (mul+1) / ((div1+1) × 2^div2), truncated. Candidates above the target are skipped. The engine keeps the candidate with the smallest error at or below the target and stops at once on an exact hit. Once a setting is chosen, a multi-cycle divider turns the reference rate into whole MHz. That value, divided by (div1+1), selects a loop-filter code. All fields are then packed into one configuration word that software or a sequencer writes to the PLL.

The controller has four named states. IDLE waits for start. SCAN tests one candidate per clock. QUOT runs the MHz divider. FINISH registers the results and raises done. The transitions are:
- START: IDLE to SCAN.
- HIT: SCAN to QUOT on an exact candidate.
- EXHAUST_OK: SCAN to QUOT after the last candidate, when a usable setting was found.
- EXHAUST_NONE: SCAN to FINISH after the last candidate, when no candidate fits.
- QUOT_DONE: QUOT to FINISH.
- RETIRE: FINISH to IDLE.

Top module: `pll_setting_search`

## Requirements
- R1: When valid_o is high, rate_o equals the truncated value of parent × (mul_o+1) / ((div1_o+1) × 2^div2_o) for the sampled parent rate. Intermediate products of up to 40 bits must not overflow.
- R2: The search order is fixed. div1 counts down from 1 to 0 as the outer loop. div2 counts down from 7 to 0 as the middle loop. mul counts up from 0 to 255 as the inner loop. A new candidate replaces the best one only if its error is strictly smaller, so the earliest candidate wins a tie.
- R3: A reported setting never exceeds the target: with valid_o high, rate_o ≤ target.
- R4: A candidate with zero error ends the scan immediately. An exact hit on the fourth candidate produces done within 60 clocks of start.
- R5: If no candidate is at or below the target, the engine finishes with error_o = 1 and valid_o = 0. In that case the fields, cfg_o and rate_o are all zero. valid_o and error_o are never high together.
- R6: The filter code is computed from f = floor(floor(parent / 1,000,000) / (div1+1)). The code is 7 for f ≥ 166, 6 for f ≥ 104, 5 for f ≥ 65, 4 for f ≥ 42, 3 for f ≥ 26, 2 for f ≥ 16, 1 for f ≥ 10, and 0 below 10.
- R7: cfg_o holds the fields at fixed positions: filter in bits 26:24, mul in bits 23:16, div1 in bit 8 and div2 in bits 2:0. Every other bit is zero.
- R8: A start pulse that arrives while a search is running is ignored. The result still belongs to the first request.
- R9: done_o is high for exactly one clock. The result outputs hold their values until the next accepted start, which clears valid_o and error_o.
- R10: After reset, done_o, valid_o, error_o, cfg_o and rate_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a search; sampled only when idle |
| parent_i | input | 32 | Reference rate in Hz |
| target_i | input | 32 | Requested output rate in Hz |
| done_o | output | 1 | One-clock completion pulse |
| valid_o | output | 1 | A setting was found |
| error_o | output | 1 | No setting at or below the target exists |
| mul_o | output | 8 | Chosen multiplier field |
| div1_o | output | 1 | Chosen pre-divider field |
| div2_o | output | 3 | Chosen power-of-two post-divider exponent |
| filter_o | output | 3 | Loop-filter code |
| cfg_o | output | 32 | Packed configuration word |
| rate_o | output | 32 | Output rate the chosen setting achieves |

## Verification
Several request patterns are used, and each one separates a different behaviour.
- Exact targets that are reachable early or late in the order show whether the scan stops at the first zero-error candidate and whether the loops run in the right direction.
- Targets just below an exact rate exercise the track-best comparison.
- A zero reference rate makes every candidate tie, which exposes a comparison that is not strict.
- A huge target against a large reference forces products wider than 32 bits.
- A target below the smallest candidate reaches the error path.
- Reference rates that give different MHz quotients land on several different filter codes.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_QUOT,
        ST_FINISH
    } srch_state_t;

    // Loop-filter band selection from the pre-divided reference in MHz.
    function automatic logic [2:0] filt_code(input logic [31:0] mhz);
        logic [2:0] code;
        if (mhz >= 32'd166)      code = 3'd7;
        else if (mhz >= 32'd104) code = 3'd6;
        else if (mhz >= 32'd65)  code = 3'd5;
        else if (mhz >= 32'd42)  code = 3'd4;
        else if (mhz >= 32'd26)  code = 3'd3;
        else if (mhz >= 32'd16)  code = 3'd2;
        else if (mhz >= 32'd10)  code = 3'd1;
        else                     code = 3'd0;
        return code;
    endfunction

endpackage

// File: rtl/pllsrch_div.sv
module pllsrch_div #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         done_o,
    output logic [W-1:0] quo_o
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem_q;
    logic [W-1:0]  quo_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [W:0]    shifted;
    logic          fits;

    // Restoring division: one quotient bit per clock.
    assign shifted = {rem_q[W-1:0], quo_q[W-1]};
    assign fits    = shifted >= {1'b0, den_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rem_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go_i) begin
                rem_q <= '0;
                quo_q <= num_i;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? (shifted - {1'b0, den_i}) : shifted;
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q  <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign quo_o = quo_q;

    AST_DIV_DONE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !run_q); // R6

endmodule

// File: rtl/pllsrch_cand.sv
module pllsrch_cand #(
    parameter int RATE_W = 32,
    parameter int MUL_W  = 8,
    parameter int D2_W   = 3
) (
    input  logic [RATE_W+MUL_W-1:0] acc_i,
    input  logic                    d1_i,
    input  logic [D2_W-1:0]         d2_i,
    input  logic [RATE_W-1:0]       target_i,
    output logic                    fits_o,
    output logic [RATE_W-1:0]       rate_o,
    output logic [RATE_W-1:0]       err_o
);
    localparam int PROD_W = RATE_W + MUL_W;
    localparam int SH_W   = D2_W + 1;

    logic [SH_W-1:0]   sh;
    logic [PROD_W-1:0] full;

    // Both divisors are powers of two, so the division is one shift.
    assign sh     = SH_W'(d2_i) + SH_W'(d1_i);
    assign full   = acc_i >> sh;
    assign fits_o = full <= PROD_W'(target_i);
    assign rate_o = RATE_W'(full);
    assign err_o  = target_i - RATE_W'(full);

endmodule

// File: rtl/pllsrch_best.sv
module pllsrch_best #(
    parameter int RATE_W = 32,
    parameter int MUL_W  = 8,
    parameter int D2_W   = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              en_i,
    input  logic              fits_i,
    input  logic [RATE_W-1:0] err_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [MUL_W-1:0]  mul_i,
    input  logic              d1_i,
    input  logic [D2_W-1:0]   d2_i,
    output logic              take_o,
    output logic              found_o,
    output logic [RATE_W-1:0] rate_o,
    output logic [MUL_W-1:0]  mul_o,
    output logic              d1_o,
    output logic [D2_W-1:0]   d2_o
);
    logic [RATE_W-1:0] err_q;

    // Strictly-smaller test keeps the earliest of equal candidates.
    assign take_o = en_i && fits_i && (!found_o || (err_i < err_q));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            found_o <= 1'b0;
            err_q   <= '0;
            rate_o  <= '0;
            mul_o   <= '0;
            d1_o    <= 1'b0;
            d2_o    <= '0;
        end else if (clear_i) begin
            found_o <= 1'b0;
        end else if (take_o) begin
            found_o <= 1'b1;
            err_q   <= err_i;
            rate_o  <= rate_i;
            mul_o   <= mul_i;
            d1_o    <= d1_i;
            d2_o    <= d2_i;
        end
    end

    AST_BEST_NEVER_WORSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (found_o && !clear_i) |=> (err_q <= $past(err_q))); // R2

endmodule

// File: rtl/pll_setting_search.sv
module pll_setting_search
    import pllsrch_pkg::*;
#(
    parameter int RATE_W = 32,
    parameter int MUL_W  = 8,
    parameter int D2_W   = 3,
    parameter int CFG_W  = 32,
    parameter int MHZ_HZ = 1_000_000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [RATE_W-1:0] parent_i,
    input  logic [RATE_W-1:0] target_i,
    output logic              done_o,
    output logic              valid_o,
    output logic              error_o,
    output logic [MUL_W-1:0]  mul_o,
    output logic              div1_o,
    output logic [D2_W-1:0]   div2_o,
    output logic [2:0]        filter_o,
    output logic [CFG_W-1:0]  cfg_o,
    output logic [RATE_W-1:0] rate_o
);
    localparam int               PROD_W  = RATE_W + MUL_W;
    localparam logic [MUL_W-1:0] MUL_MAX = {MUL_W{1'b1}};
    localparam logic [D2_W-1:0]  D2_MAX  = {D2_W{1'b1}};
    localparam int               FILT_LO = 24;
    localparam int               MUL_LO  = 16;
    localparam int               D1_POS  = 8;

    srch_state_t state_q, state_d;

    logic [RATE_W-1:0] parent_q, target_q;
    logic [PROD_W-1:0] acc_q;
    logic [MUL_W-1:0]  mul_q;
    logic              d1_q;
    logic [D2_W-1:0]   d2_q;

    logic              accept, scanning, step_end, last_step, hit, found_any;
    logic              c_fits;
    logic [RATE_W-1:0] c_rate, c_err;
    logic              take, b_found, b_d1;
    logic [RATE_W-1:0] b_rate;
    logic [MUL_W-1:0]  b_mul;
    logic [D2_W-1:0]   b_d2;
    logic              div_go, div_done;
    logic [RATE_W-1:0] mhz_q;
    logic [2:0]        filt_n;
    logic [CFG_W-1:0]  cfg_n;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign scanning  = (state_q == ST_SCAN);
    assign step_end  = !c_fits || (mul_q == MUL_MAX);
    assign last_step = step_end && (d2_q == '0) && !d1_q;
    assign hit       = take && (c_err == '0);
    assign found_any = b_found || take;

    pllsrch_cand #(.RATE_W(RATE_W), .MUL_W(MUL_W), .D2_W(D2_W)) i_cand (
        .acc_i    (acc_q),
        .d1_i     (d1_q),
        .d2_i     (d2_q),
        .target_i (target_q),
        .fits_o   (c_fits),
        .rate_o   (c_rate),
        .err_o    (c_err)
    );

    pllsrch_best #(.RATE_W(RATE_W), .MUL_W(MUL_W), .D2_W(D2_W)) i_best (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (accept),
        .en_i    (scanning),
        .fits_i  (c_fits),
        .err_i   (c_err),
        .rate_i  (c_rate),
        .mul_i   (mul_q),
        .d1_i    (d1_q),
        .d2_i    (d2_q),
        .take_o  (take),
        .found_o (b_found),
        .rate_o  (b_rate),
        .mul_o   (b_mul),
        .d1_o    (b_d1),
        .d2_o    (b_d2)
    );

    assign div_go = scanning && (state_d == ST_QUOT);

    pllsrch_div #(.W(RATE_W)) i_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (div_go),
        .num_i  (parent_q),
        .den_i  (RATE_W'(MHZ_HZ)),
        .done_o (div_done),
        .quo_o  (mhz_q)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_SCAN;                       // START
            ST_SCAN: begin
                if (hit)            state_d = ST_QUOT;                       // HIT
                else if (last_step) state_d = found_any ? ST_QUOT            // EXHAUST_OK
                                                        : ST_FINISH;         // EXHAUST_NONE
            end
            ST_QUOT:   if (div_done) state_d = ST_FINISH;                    // QUOT_DONE
            ST_FINISH: state_d = ST_IDLE;                                    // RETIRE
            default:   state_d = ST_IDLE;
        endcase
    end

    // Search indices and running product parent*(mul+1)
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            parent_q <= '0;
            target_q <= '0;
            acc_q    <= '0;
            mul_q    <= '0;
            d1_q     <= 1'b0;
            d2_q     <= '0;
        end else if (accept) begin
            parent_q <= parent_i;
            target_q <= target_i;
            acc_q    <= PROD_W'(parent_i);
            mul_q    <= '0;
            d1_q     <= 1'b1;
            d2_q     <= D2_MAX;
        end else if (scanning) begin
            if (step_end) begin
                // A larger mul can only raise the rate: skip the rest of this row.
                mul_q <= '0;
                acc_q <= PROD_W'(parent_q);
                if (d2_q == '0) begin
                    d2_q <= D2_MAX;
                    d1_q <= 1'b0;
                end else begin
                    d2_q <= d2_q - 1'b1;
                end
            end else begin
                mul_q <= mul_q + 1'b1;
                acc_q <= acc_q + PROD_W'(parent_q);
            end
        end
    end

    assign filt_n = filt_code(32'(mhz_q >> b_d1));

    always_comb begin
        cfg_n                        = '0;
        cfg_n[FILT_LO +: 3]          = filt_n;
        cfg_n[MUL_LO +: MUL_W]       = b_mul;
        cfg_n[D1_POS]                = b_d1;
        cfg_n[0 +: D2_W]             = b_d2;
    end

    // Outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            done_o   <= 1'b0;
            valid_o  <= 1'b0;
            error_o  <= 1'b0;
            mul_o    <= '0;
            div1_o   <= 1'b0;
            div2_o   <= '0;
            filter_o <= '0;
            cfg_o    <= '0;
            rate_o   <= '0;
        end else begin
            done_o <= (state_q == ST_FINISH);
            if (accept) begin
                valid_o <= 1'b0;
                error_o <= 1'b0;
            end else if (state_q == ST_FINISH) begin
                valid_o  <= b_found;
                error_o  <= !b_found;
                mul_o    <= b_found ? b_mul  : '0;
                div1_o   <= b_found ? b_d1   : 1'b0;
                div2_o   <= b_found ? b_d2   : '0;
                filter_o <= b_found ? filt_n : '0;
                cfg_o    <= b_found ? cfg_n  : '0;
                rate_o   <= b_found ? b_rate : '0;
            end
        end
    end

    AST_NEVER_ABOVE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (rate_o <= target_q)); // R3
    AST_VALID_ERROR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(valid_o && error_o)); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R9
    AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE) |=> ($stable(cfg_o) && $stable(rate_o))); // R9
    AST_BUSY_KEEPS_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_IDLE) |=> $stable(target_q)); // R8

endmodule

// File: tb/test_pll_setting_search.sv
module test_pll_setting_search;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] parent = '0, target = '0;
    logic        done, valid, error_f, div1;
    logic [7:0]  mul;
    logic [2:0]  div2, filt;
    logic [31:0] cfg, rate;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    pll_setting_search i_pll_setting_search (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .parent_i(parent), .target_i(target),
        .done_o(done), .valid_o(valid), .error_o(error_f),
        .mul_o(mul), .div1_o(div1), .div2_o(div2), .filter_o(filt),
        .cfg_o(cfg), .rate_o(rate)
    );

    localparam int NV = 12;
    localparam logic [31:0] VEC_P [NV] = '{
        32'd25_000_000, 32'd25_000_000, 32'd25_000_000, 32'd24_000_000,
        32'd0,          32'd200_000_000, 32'd10_000_000, 32'd33_333_333,
        32'd1_000_000,  32'd170_000_000, 32'hFFFF_FFFF,  32'd16_000_000};
    localparam logic [31:0] VEC_T [NV] = '{
        32'd390_625,     32'd1_000_000_000, 32'd999_999_999, 32'd1,
        32'd12_345,      32'd700_000_000,   32'd123_456_789, 32'hFFFF_FFFF,
        32'd3_906,       32'd170_000_000,   32'hFFFF_FFFF,   32'd16_000_000};

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Model of the requirements (R1, R2, R5, R6, R7).
    task automatic model(input longint unsigned p, input longint unsigned t,
                         output bit ok, output int m_o, output int d1_o, output int d2_o,
                         output longint unsigned r_o, output int f_o, output longint unsigned w_o);
        longint unsigned best_e;
        bit stop;
        ok = 0; m_o = 0; d1_o = 0; d2_o = 0; r_o = 0; best_e = 0; stop = 0;
        for (int a = 1; a >= 0 && !stop; a--)
            for (int b = 7; b >= 0 && !stop; b--)
                for (int m = 0; m <= 255 && !stop; m++) begin
                    longint unsigned c;
                    c = (p * longint'(m + 1)) / (longint'(a + 1) << b);
                    if (c <= t && (!ok || (t - c) < best_e)) begin
                        ok = 1; best_e = t - c; m_o = m; d1_o = a; d2_o = b; r_o = c;
                        if (best_e == 0) stop = 1;
                    end
                end
        begin
            longint unsigned f;
            f = (p / 1_000_000) / longint'(d1_o + 1);
            f_o = f >= 166 ? 7 : f >= 104 ? 6 : f >= 65 ? 5 : f >= 42 ? 4 :
                  f >= 26 ? 3 : f >= 16 ? 2 : f >= 10 ? 1 : 0;
        end
        if (!ok) begin f_o = 0; end
        w_o = ok ? ((longint'(f_o) << 24) | (longint'(m_o) << 16) |
                    (longint'(d1_o) << 8) | longint'(d2_o)) : 0;
    endtask

    task automatic kick(input logic [31:0] p, input logic [31:0] t);
        @(negedge clk);
        parent = p; target = t; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 1;
        while (!done && lat < 20000) begin
            @(negedge clk);
            lat++;
        end
        chk("R9 done seen", done, 1);
    endtask

    task automatic compare(input logic [31:0] p, input logic [31:0] t, input string tag);
        bit ok; int m, a, b, f; longint unsigned r, w;
        model(p, t, ok, m, a, b, r, f, w);
        chk({tag, " R5 valid"}, valid, ok);
        chk({tag, " R5 error"}, error_f, !ok);
        chk({tag, " R2 mul"}, mul, ok ? m : 0);
        chk({tag, " R2 div1"}, div1, ok ? a : 0);
        chk({tag, " R2 div2"}, div2, ok ? b : 0);
        chk({tag, " R1 rate"}, rate, r);
        chk({tag, " R3 rate<=target"}, (rate <= t), 1);
        chk({tag, " R6 filter"}, filt, f);
        chk({tag, " R7 word"}, cfg, w);
    endtask

    initial begin
        #(20 * 190_000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 done", done, 0);
        chk("R10 valid", valid, 0);
        chk("R10 error", error_f, 0);
        chk("R10 cfg", cfg, 0);
        chk("R10 rate", rate, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            kick(VEC_P[i], VEC_T[i]);
            wait_done(lat);
            compare(VEC_P[i], VEC_T[i], $sformatf("vec%0d", i));
            if (i == 0) chk("R4 early exit latency < 60", (lat < 60), 1);
            if (i == 7) chk("R4 full scan is long", (lat > 2000), 1);
        end

        // R9: done lasts one cycle, results hold while idle
        kick(32'd25_000_000, 32'd999_999_999);
        wait_done(lat);
        @(negedge clk);
        chk("R9 done low after one cycle", done, 0);
        repeat (20) @(negedge clk);
        parent = 32'd5; target = 32'd7;
        @(negedge clk);
        compare(32'd25_000_000, 32'd999_999_999, "hold");

        // R8: second start during a search is ignored
        kick(32'd25_000_000, 32'd999_999_999);
        repeat (3) @(negedge clk);
        parent = 32'd1_000_000; target = 32'd3_906; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        compare(32'd25_000_000, 32'd999_999_999, "R8 busy");

        // R9: accepted start clears valid
        kick(32'd24_000_000, 32'd1);
        chk("R9 valid cleared on start", valid, 0);
        wait_done(lat);
        compare(32'd24_000_000, 32'd1, "R5 err");

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule